// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block watches the eight pins of a general-purpose port and raises one interrupt request when an enabled pin reaches its active condition. Software picks the pins that take part, the active polarity of each pin, and whether the block detects transitions only or transitions together with steady active levels. Each pin passes through a two-flop synchronizer before any detection. A single sticky flag records that an interrupt occurred. Software clears the flag by writing a self-clearing acknowledge bit, and the flag drives the request line only while the interrupt enable is set.

Software reaches the block through a small synchronous register port. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The asynchronous active-low reset is released on a clock edge through an internal two-stage reset synchronizer.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, the control/status register (address 0), the pin-enable register (address 1) and the polarity register (address 2) all read 0x00, and `irq_o` is 0.
- R2: Address 0 reads {4'b0000, flag, 1'b0, ie, mode}: flag at bit 3, acknowledge at bit 2 (always reads 0), interrupt enable at bit 1, mode at bit 0, bits 7:4 read 0. Address 1 reads the pin enables and address 2 reads the polarities. Address 3 reads 0x00 and writes to it change nothing.
- R3: A write of 1 to bit 3 of address 0 never changes the flag.
- R4: A write to address 0 with bit 2 set clears the flag at that clock edge when no detection condition is present.
- R5: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R6: In edge mode (mode=0), a change of an enabled pin from inactive to active sets the flag. The active level is high when that pin's polarity bit is 1 and low when it is 0. The flag is readable after the third rising clock edge following the pin change. A change from active to inactive does not set the flag.
- R7: In level mode (mode=1), an enabled pin held at its active level sets the flag, and an acknowledge does not clear the flag while that level persists. Once the level is gone, the flag stays set until it is acknowledged.
- R8: A pin whose enable bit is 0 never sets the flag, by edge or by level.
- R9: When a detection and an acknowledge write fall on the same clock edge, the flag is 1 after that edge.
- R10: Writing the pin-enable or polarity register never produces an edge detection by itself.
- R11: In edge mode, a pin that stays at its active level does not set the flag again after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change becomes a flag change on the third rising clock edge: two edges pass through the synchronizer and one sets the flag register. The bench changes pins on a falling edge. It samples the flag one falling edge before its due cycle, where the flag must still be 0, and again on the due falling edge. Register writes, acknowledges and enable changes take effect on the next rising edge, so they are read back at the following falling edge. `irq_o` and `rdata` are combinational and are sampled a step after the falling edge. The same-edge case for set-beats-clear is built by placing the acknowledge strobe on the third rising edge after a pin change.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] A_POL  = 2'd2;

  localparam int unsigned B_MODE = 0;
  localparam int unsigned B_IE   = 1;
  localparam int unsigned B_ACK  = 2;
  localparam int unsigned B_FLAG = 3;
endpackage

// File: rtl/pin_irq_rst_sync.sv
module pin_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] en,
  input  logic         mode,
  input  logic         cfg_wr,
  output logic         set_evt
);
  logic [W-1:0] act;
  logic [W-1:0] act_q;
  logic         refresh_q;
  logic [W-1:0] edge_v;
  logic [W-1:0] lvl_v;
  logic         edge_any;
  logic         lvl_any;

  always_comb begin
    act      = ~(pin_s ^ pol);
    edge_v   = act & ~act_q & en;
    lvl_v    = act & en;
    edge_any = (|edge_v) & ~refresh_q;
    lvl_any  = mode & (|lvl_v);
    set_evt  = edge_any | lvl_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= '0;
      refresh_q <= 1'b0;
    end else begin
      act_q     <= act;
      refresh_q <= cfg_wr;
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq_o
);
  logic         rst_sn;
  logic [W-1:0] pin_s;
  logic         set_evt;

  logic         flag_q, flag_d;
  logic         ie_q,   ie_d;
  logic         mode_q, mode_d;
  logic [W-1:0] en_q,   en_d;
  logic [W-1:0] pol_q,  pol_d;

  logic         wr_ctrl, wr_en_reg, wr_pol, ack, cfg_wr;

  pin_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  pin_irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(pin_i), .q_o(pin_s)
  );

  pin_irq_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_sn), .pin_s(pin_s), .pol(pol_q), .en(en_q),
    .mode(mode_q), .cfg_wr(cfg_wr), .set_evt(set_evt)
  );

  always_comb begin
    wr_ctrl   = wr_en && (addr == A_CTRL);
    wr_en_reg = wr_en && (addr == A_EN);
    wr_pol    = wr_en && (addr == A_POL);
    ack       = wr_ctrl && wdata[B_ACK];
    cfg_wr    = wr_en_reg || wr_pol;

    ie_d   = wr_ctrl   ? wdata[B_IE]   : ie_q;
    mode_d = wr_ctrl   ? wdata[B_MODE] : mode_q;
    en_d   = wr_en_reg ? wdata         : en_q;
    pol_d  = wr_pol    ? wdata         : pol_q;
    flag_d = set_evt | (flag_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= 1'b0;
      en_q   <= '0;
      pol_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      pol_q  <= pol_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[B_FLAG] = flag_q;
        rdata[B_IE]   = ie_q;
        rdata[B_MODE] = mode_q;
      end
      A_EN:    rdata = en_q;
      A_POL:   rdata = pol_q;
      default: rdata = '0;
    endcase
  end

  assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flag,
  input logic         set_evt,
  input logic         mode,
  input logic [W-1:0] pin_en,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata
);
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[2] && !set_evt) |=> !flag);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[2] && set_evt) |=> flag);

  // R8
  no_enable_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> (pin_en != '0));

  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[7:4] == 4'b0000 && rdata[2] == 1'b0));

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && (addr == 2'd1 || addr == 2'd2)) && !mode) |-> !set_evt);
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .flag(flag_q), .set_evt(set_evt),
  .mode(mode_q), .pin_en(en_q), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata)
);

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // {addr, wdata, expected read-back}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'hFF, 8'h03},
    {2'd0, 8'h0A, 8'h02},
    {2'd1, 8'hA5, 8'hA5},
    {2'd2, 8'h3C, 8'h3C},
    {2'd3, 8'hFF, 8'h00},
    {2'd0, 8'h00, 8'h00},
    {2'd1, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00}
  };

  pin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic flag_is(input string tag, input logic exp);
    logic [7:0] v;
    do_rd(2'd0, v);
    check(tag, {7'd0, v[3]}, {7'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    do_rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    do_rd(2'd1, v); check("R1 en", v, 8'h00);
    do_rd(2'd2, v); check("R1 pol", v, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2 R3 register vectors
    for (int k = 0; k < 8; k++) begin
      do_wr(VEC[k][17:16], VEC[k][15:8]);
      do_rd(VEC[k][17:16], v);
      check($sformatf("R2/R3 vec %0d", k), v, VEC[k][7:0]);
    end

    // setup: pin0 rising active, enabled, ie=1, mode 0
    do_wr(2'd2, 8'h01);
    do_wr(2'd1, 8'h01);
    do_wr(2'd0, 8'h02);
    wait_n(3);
    flag_is("R10 setup quiet", 1'b0);

    // R6 rising edge timing
    @(negedge clk); pin_i = 8'h01;
    @(negedge clk);
    @(negedge clk); flag_is("R6 not yet", 1'b0);
    @(negedge clk); flag_is("R6 edge sets", 1'b1);
    check("R5 irq on", {7'd0, irq_o}, 8'h01);

    // R4 ack and R11 steady level in edge mode
    do_wr(2'd0, 8'h06);
    flag_is("R4 ack clears", 1'b0);
    wait_n(4);
    flag_is("R11 steady level", 1'b0);

    // R6 inactive transition ignored
    @(negedge clk); pin_i = 8'h00;
    wait_n(4);
    flag_is("R6 falling ignored", 1'b0);

    // R5 gating by ie
    do_wr(2'd0, 8'h00);
    @(negedge clk); pin_i = 8'h01;
    wait_n(3);
    flag_is("R5 flag set ie off", 1'b1);
    check("R5 irq off", {7'd0, irq_o}, 8'h00);
    do_wr(2'd0, 8'h02);
    check("R5 irq after ie", {7'd0, irq_o}, 8'h01);
    do_wr(2'd0, 8'h06);
    check("R5 irq after ack", {7'd0, irq_o}, 8'h00);

    // R6 active-low polarity
    do_wr(2'd2, 8'h00);
    wait_n(3);
    flag_is("R10 pol to low quiet", 1'b0);
    @(negedge clk); pin_i = 8'h00;
    wait_n(3);
    flag_is("R6 falling active low", 1'b1);
    do_wr(2'd0, 8'h06);

    // R10 polarity flip back and forth while pin active
    do_wr(2'd2, 8'h01);
    do_wr(2'd2, 8'h00);
    wait_n(4);
    flag_is("R10 pol flip quiet", 1'b0);
    do_wr(2'd1, 8'h00);
    do_wr(2'd1, 8'h01);
    wait_n(4);
    flag_is("R10 enable flip quiet", 1'b0);

    // R8 disabled pins toggle
    @(negedge clk); pin_i = 8'hFE;
    wait_n(4);
    @(negedge clk); pin_i = 8'h00;
    wait_n(4);
    flag_is("R8 other pins edge", 1'b0);
    do_wr(2'd1, 8'h00);
    @(negedge clk); pin_i = 8'h01;
    wait_n(4);
    @(negedge clk); pin_i = 8'h00;
    wait_n(4);
    flag_is("R8 disabled edge", 1'b0);
    do_wr(2'd0, 8'h03);
    wait_n(4);
    flag_is("R8 disabled level", 1'b0);

    // R7 level mode
    @(negedge clk); pin_i = 8'h01;
    do_wr(2'd1, 8'h01);
    wait_n(4);
    flag_is("R7 inactive no flag", 1'b0);
    @(negedge clk); pin_i = 8'h00;
    wait_n(3);
    flag_is("R7 level sets", 1'b1);
    do_wr(2'd0, 8'h07);
    flag_is("R7 ack blocked", 1'b1);
    @(negedge clk); pin_i = 8'h01;
    wait_n(3);
    flag_is("R7 latched after level", 1'b1);
    do_wr(2'd0, 8'h07);
    flag_is("R7 ack after level", 1'b0);

    // R9 set and ack on the same edge (edge mode)
    do_wr(2'd0, 8'h02);
    wait_n(2);
    @(negedge clk); pin_i = 8'h00;
    @(negedge clk);
    do_wr(2'd0, 8'h06);
    flag_is("R9 set beats ack", 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule